// File: doc/BRIEF.md
# Dual-Channel DAC Update Sequencer

This block drives a two-channel DAC that sits on an I2C bus. It does not drive the bus wires itself. It sits above an I2C master byte engine and gives that engine commands one at a time. A single `go` pulse captures two 8-bit sample values. The block then sends one packet that writes both channels, so both analog outputs change together when the packet ends.

The packet always has seven steps, in this order:

1. a Start condition;
2. the device address with the write bit;
3. the channel-0 command byte;
4. the channel-0 sample;
5. the channel-1 command byte;
6. the channel-1 sample;
7. a Stop condition.

The byte engine reports a result for each command. If it reports an error after any byte, the block does not send a Stop. It begins the whole packet again with a new Start, which the bus treats as a repeated Start.

A retry limit prevents a stuck bus or a missing slave from holding the block forever. When the limit is used up, the block sends a Stop, pulses `fail` and returns to idle.

Top module: `dac_pair_updater`

## Requirements
- R1: A `go` pulse while idle captures both samples and raises `busy` in the next cycle. A `go` pulse while `busy` is high is ignored: it causes no second packet and no extra `done` or `fail` pulse.
- R2: Each attempt issues the commands in this order: Start, address, channel-0 command, sample 0, channel-1 command, sample 1. A successful attempt is followed by one Stop. The op encoding on `cmd_op` is 0 for Start, 1 for byte write and 2 for Stop.
- R3: The address byte is the 5-bit device code 01011, then the two `ADDR_PINS` bits, then a write bit of 0. This gives 8'h58 with the default `ADDR_PINS` of 0.
- R4: The channel-0 command byte is 8'h00 and the channel-1 command byte is 8'h01. The sample bytes carry the values captured at `go`. Changes on `sample0` or `sample1` during the transfer have no effect.
- R5: An error response to any byte write makes the next command a Start, with no Stop in between, and the full packet is sent again from the address byte.
- R6: At most `MAX_RETRY` restarts (default 4) are made. An error on attempt `MAX_RETRY`+1 makes the next command a Stop. After that Stop completes, `fail` pulses for one cycle and the block returns to idle.
- R7: After the Stop of a successful attempt completes, `done` pulses for one cycle, in the cycle after the Stop response. `busy` is low in that same cycle. `done` and `fail` are never high together.
- R8: `cmd_valid` stays high with stable `cmd_op` and `cmd_byte` until `cmd_ready` accepts the command. No new command is offered while a response is still outstanding.
- R9: After reset the block is idle, with `busy`, `done`, `fail` and `cmd_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start an update of both channels |
| sample0 | input | 8 | Channel-0 value, captured on an accepted `go` |
| sample1 | input | 8 | Channel-1 value, captured on an accepted `go` |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle pulse: packet completed successfully |
| fail | output | 1 | One-cycle pulse: retries exhausted, bus stopped |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the offered command |
| cmd_op | output | 2 | 0 Start, 1 write byte, 2 Stop |
| cmd_byte | output | 8 | Byte to write when `cmd_op` is 1 |
| rsp_valid | input | 1 | Byte engine finished the last accepted command |
| rsp_err | input | 1 | With `rsp_valid`: the byte was not acknowledged |

## Verification
The sequencer is first run clean with sample pairs chosen to make a swap or bit-order error visible:

- all-zero against all-one;
- alternating bit patterns;
- single set bits at opposite ends.

These runs separate the two channels and the two data slots.

A sweep then covers every no-acknowledge pattern over the first six byte writes. This sweep separates three cases:

- a restart that begins too late or without a fresh Start;
- a retry count that stops one attempt early or one attempt late;
- an abort that skips its Stop.

Every run changes the sample inputs and pulses `go` again during the transfer. The expected byte stream therefore shows whether the inputs were captured once and held.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

    localparam int BYTE_W = 8;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_STOP  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } state_e;

    localparam logic [STEP_W-1:0] STEP_FIRST = 3'd0;
    localparam logic [STEP_W-1:0] STEP_STOP  = 3'd6;

    localparam logic [4:0]        DEV_CODE = 5'b01011;
    localparam logic [BYTE_W-1:0] CMD_CH0  = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_CH1  = 8'h01;

    typedef struct packed {
        state_e            st;
        logic [STEP_W-1:0] step;
        logic [BYTE_W-1:0] smp0;
        logic [BYTE_W-1:0] smp1;
        logic              aborting;
        logic              done;
        logic              fail;
    } ctl_t;

endpackage

// File: rtl/dpu_packet_rom.sv
module dpu_packet_rom
    import dpu_pkg::*;
#(
    parameter logic [1:0] ADDR_PINS = 2'b00
) (
    input  logic [STEP_W-1:0] step,
    input  logic [BYTE_W-1:0] smp0,
    input  logic [BYTE_W-1:0] smp1,
    output op_e               op,
    output logic [BYTE_W-1:0] data
);

    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_CODE, ADDR_PINS, 1'b0};

    always_comb begin
        op   = OP_WRITE;
        data = '0;
        case (step)
            3'd0: begin
                op   = OP_START;
                data = '0;
            end
            3'd1: data = ADDR_BYTE;
            3'd2: data = CMD_CH0;
            3'd3: data = smp0;
            3'd4: data = CMD_CH1;
            3'd5: data = smp1;
            default: begin
                op   = OP_STOP;
                data = '0;
            end
        endcase
    end

endmodule

// File: rtl/dpu_retry_ctr.sv
module dpu_retry_ctr #(
    parameter int MAX_RETRY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CNT_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q == LIMIT);

endmodule

// File: rtl/dac_pair_updater.sv
module dac_pair_updater
    import dpu_pkg::*;
#(
    parameter logic [1:0] ADDR_PINS = 2'b00,
    parameter int         MAX_RETRY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] sample0,
    input  logic [7:0] sample1,
    output logic       busy,
    output logic       done,
    output logic       fail,
    output logic       cmd_valid,
    input  logic       cmd_ready,
    output logic [1:0] cmd_op,
    output logic [7:0] cmd_byte,
    input  logic       rsp_valid,
    input  logic       rsp_err
);

    ctl_t              ctl_d, ctl_q;
    op_e               cur_op;
    logic [BYTE_W-1:0] cur_byte;
    logic              retry_clr, retry_inc, retry_full;

    dpu_packet_rom #(
        .ADDR_PINS (ADDR_PINS)
    ) u_rom (
        .step (ctl_q.step),
        .smp0 (ctl_q.smp0),
        .smp1 (ctl_q.smp1),
        .op   (cur_op),
        .data (cur_byte)
    );

    dpu_retry_ctr #(
        .MAX_RETRY (MAX_RETRY)
    ) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (retry_clr),
        .inc      (retry_inc),
        .at_limit (retry_full)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.fail = 1'b0;
        retry_clr  = 1'b0;
        retry_inc  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (go) begin
                    ctl_d.smp0     = sample0;
                    ctl_d.smp1     = sample1;
                    ctl_d.step     = STEP_FIRST;
                    ctl_d.aborting = 1'b0;
                    ctl_d.st       = ST_ISSUE;
                    retry_clr      = 1'b1;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (cur_op == OP_WRITE && rsp_err) begin
                        ctl_d.st = ST_ISSUE;
                        if (retry_full) begin
                            ctl_d.step     = STEP_STOP;
                            ctl_d.aborting = 1'b1;
                        end else begin
                            ctl_d.step = STEP_FIRST;
                            retry_inc  = 1'b1;
                        end
                    end else if (cur_op == OP_STOP) begin
                        ctl_d.st = ST_IDLE;
                        if (ctl_q.aborting) begin
                            ctl_d.fail = 1'b1;
                        end else begin
                            ctl_d.done = 1'b1;
                        end
                    end else begin
                        ctl_d.step = ctl_q.step + 1'b1;
                        ctl_d.st   = ST_ISSUE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, step: STEP_FIRST, smp0: '0, smp1: '0,
                       aborting: 1'b0, done: 1'b0, fail: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != ST_IDLE);
    assign done      = ctl_q.done;
    assign fail      = ctl_q.fail;
    assign cmd_valid = (ctl_q.st == ST_ISSUE);
    assign cmd_op    = cur_op;
    assign cmd_byte  = cur_byte;

endmodule

// File: rtl/dpu_chk.sv
module dpu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic       fail,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       rsp_valid,
    input logic       rsp_err
);

    logic [1:0] last_op_q;
    logic       pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_op_q <= 2'd0;
            pending_q <= 1'b0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                last_op_q <= cmd_op;
                pending_q <= 1'b1;
            end else if (rsp_valid) begin
                pending_q <= 1'b0;
            end
        end
    end

    // R1
    go_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> busy);

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !cmd_valid);

    // R5
    restart_after_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && pending_q && last_op_q == 2'd1) |=> (cmd_valid && cmd_op != 2'd1));

    // R7
    done_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rsp_valid) && !busy));

    // R6
    fail_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> ($past(rsp_valid) && !busy));

    // R7
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

endmodule

bind dac_pair_updater dpu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err)
);

// File: tb/dac_pair_updater_tb.sv
module dac_pair_updater_tb;

    localparam int MAX_RETRY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [7:0] sample0 = '0, sample1 = '0;
    logic       busy, done, fail, cmd_valid, cmd_ready, rsp_valid, rsp_err;
    logic [1:0] cmd_op;
    logic [7:0] cmd_byte;

    always #2 clk = ~clk;

    dac_pair_updater #(.ADDR_PINS(2'b00), .MAX_RETRY(MAX_RETRY)) u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .sample0(sample0), .sample1(sample1),
        .busy(busy), .done(done), .fail(fail), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err)
    );

    // Stub byte engine: logs commands, answers after a latency, injects errors.
    logic [1:0]  log_op [64];
    logic [7:0]  log_byte [64];
    int          log_n = 0, wr_idx = 0, done_n = 0, fail_n = 0;
    logic        log_clr = 1'b0;
    logic [63:0] nack_mask = '0;
    int          lat = 0;
    logic        pend = 1'b0, perr = 1'b0;
    int          cnt = 0;

    assign cmd_ready = !pend;

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (!rst_n || log_clr) begin
            pend <= 1'b0; log_n <= 0; wr_idx <= 0; done_n <= 0; fail_n <= 0;
            rsp_err <= 1'b0;
        end else begin
            if (done) done_n <= done_n + 1;
            if (fail) fail_n <= fail_n + 1;
            if (pend) begin
                if (cnt == 0) begin
                    rsp_valid <= 1'b1; rsp_err <= perr; pend <= 1'b0;
                end else cnt <= cnt - 1;
            end else if (cmd_valid) begin
                if (log_n < 64) begin
                    log_op[log_n] <= cmd_op; log_byte[log_n] <= cmd_byte;
                end
                log_n <= log_n + 1;
                pend  <= 1'b1;
                cnt   <= lat;
                perr  <= (cmd_op == 2'd1) && nack_mask[wr_idx[5:0]];
                if (cmd_op == 2'd1) wr_idx <= wr_idx + 1;
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [1:0] exp_op [64];
    logic [7:0] exp_byte [64];
    int         exp_n;
    logic       exp_fail;

    task automatic build_expected(input logic [7:0] a, input logic [7:0] b, input logic [63:0] mask);
        logic [7:0] pkt [5];
        int w = 0, retries = 0;
        logic finished = 1'b0;
        pkt[0] = 8'h58; pkt[1] = 8'h00; pkt[2] = a; pkt[3] = 8'h01; pkt[4] = b;
        exp_n = 0; exp_fail = 1'b0;
        while (!finished) begin
            logic err = 1'b0;
            exp_op[exp_n] = 2'd0; exp_byte[exp_n] = 8'h00; exp_n++;
            for (int k = 0; k < 5 && !err; k++) begin
                exp_op[exp_n] = 2'd1; exp_byte[exp_n] = pkt[k]; exp_n++;
                err = mask[w];
                w++;
            end
            if (err && retries < MAX_RETRY) begin
                retries++;
            end else begin
                exp_op[exp_n] = 2'd2; exp_byte[exp_n] = 8'h00; exp_n++;
                exp_fail = err;
                finished = 1'b1;
            end
        end
    endtask

    task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [63:0] mask, input int latency);
        int   waitc = 0;
        logic got_done, got_fail;
        build_expected(a, b, mask);
        @(negedge clk);
        log_clr = 1'b1; nack_mask = mask; lat = latency;
        @(negedge clk);
        log_clr = 1'b0;
        sample0 = a; sample1 = b; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R1", "busy after go", int'(busy), 1);
        sample0 = ~a; sample1 = b ^ 8'h5A;
        repeat (3) @(negedge clk);
        go = 1'b1; sample0 = 8'hEE; sample1 = 8'h11;
        @(negedge clk);
        go = 1'b0;
        while (!done && !fail && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        got_done = done; got_fail = fail;
        check(exp_fail ? "R6" : "R7", "done pulse", int'(got_done), int'(!exp_fail));
        check(exp_fail ? "R6" : "R7", "fail pulse", int'(got_fail), int'(exp_fail));
        check("R7", "busy low at end pulse", int'(busy), 0);
        repeat (10) @(negedge clk);
        check("R1", "one end pulse per go", done_n + fail_n, 1);
        check("R1", "idle after end", int'(busy), 0);
        check("R2", "command count", log_n, exp_n);
        check("R3", "address byte", int'(log_byte[1]), 8'h58);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check("R2", $sformatf("op %0d", i), int'(log_op[i]), int'(exp_op[i]));
            if (exp_op[i] == 2'd1)
                check("R4/R5", $sformatf("byte %0d", i), int'(log_byte[i]), int'(exp_byte[i]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9", "busy", int'(busy), 0);
        check("R9", "done", int'(done), 0);
        check("R9", "fail", int'(fail), 0);
        check("R9", "cmd_valid", int'(cmd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "idle after reset", int'(busy), 0);
        // R2 R4 clean runs with distinguishing sample pairs
        run(8'h00, 8'hFF, 64'h0, 0);
        run(8'hA5, 8'h5A, 64'h0, 1);
        run(8'h80, 8'h01, 64'h0, 2);
        run(8'h3C, 8'hC3, 64'h0, 0);
        for (int i = 0; i < 4; i++)
            run(8'(i * 37 + 5), 8'(i * 91 + 200), 64'h0, i % 3);
        // R5 R6 every error pattern on the first six byte writes
        for (int m = 0; m < 64; m++)
            run(8'(m * 13 + 1), 8'(255 - m * 7), 64'(m), m % 3);
        // R6 exactly at the limit, then one past it
        run(8'h12, 8'h34, 64'h0F, 1);
        run(8'h56, 8'h78, 64'h1F, 1);
        run(8'h9A, 8'hBC, 64'hFFFFFFFF, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule